// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Per-Word Valid Bits

This block is a small read-only cache that sits between a 32-bit processor request port and a 32-bit memory port. It holds 256 bytes as sixteen direct-mapped lines. Each line has four 32-bit words. All four words of a line share one tag, but every word has its own valid bit. On a miss, the cache either fetches only the missing word or fetches the whole line as a wrapping burst. It fetches the whole line only when memory reports that it can do bursts.

Software uses two controls to keep the cache coherent with external DMA masters. A per-access inhibit input sends an access straight to memory and leaves the cache untouched. A flush input clears every valid bit, so data written behind the cache is never served stale. A flush that arrives while a line fill is running waits until the fill finishes, and then clears everything.

Top module: `dm_read_cache`

## Requirements
- R1: While reset is held and on release, every word is invalid, `cpu_rvalid` and `mem_req` are low, and `cpu_ready` is high when no flush is being requested.
- R2: An accepted access hits when it is not inhibited, its line tag matches and its word is valid. A hit returns the stored word on `cpu_rdata`, with `cpu_rvalid` high, in the cycle after acceptance, and it raises no memory request.
- R3: The address is split as follows: tag in bits [31:8], line in bits [7:4], word in bits [3:2], and bits [1:0] ignored. Two addresses that are equal modulo 256 share one slot, so a fill for one evicts the other. On a miss, `mem_addr` carries the missed word's address with bits [1:0] zero.
- R4: A miss accepted while `mem_burst_cap` is low raises `mem_req` with `mem_burst` low in the next cycle, and one `mem_ack` completes it. If the line's tag changes, the tag is replaced, the fetched word becomes valid and the other three words become invalid. If the tag is unchanged, the other words keep their state.
- R5: A non-inhibited miss accepted while `mem_burst_cap` is high raises `mem_burst`. It then takes four `mem_ack` words in wrapping order (w, w+1, w+2, w+3, all mod 4), starting at the missed word w. After that, all four words of the line are valid.
- R6: The requested word appears on `cpu_rdata`, with `cpu_rvalid` high, in the cycle after the first `mem_ack` of its fill. It does not wait for the rest of a burst.
- R7: An inhibited access never hits. It always makes a single-word memory access with `mem_burst` low, and it changes no tag, valid bit or data in the cache.
- R8: A `cpu_flush` raised while the cache is idle clears every valid bit in that cycle and holds `cpu_ready` low. A `cpu_flush` raised during a fill is held until the fill finishes. It is then applied in the first idle cycle, with `cpu_ready` low, and the fill's words are not left valid.
- R9: While a fill is outstanding, `cpu_ready` stays low and `mem_req` stays high until the final `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor read request |
| cpu_addr | input | 32 | Processor byte address |
| cpu_inhibit | input | 1 | Access bypasses the cache and does not allocate |
| cpu_flush | input | 1 | Invalidate the whole cache |
| cpu_ready | output | 1 | A request is accepted in this cycle if `cpu_req` is high |
| cpu_rvalid | output | 1 | Read data is valid |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory fetch outstanding |
| mem_addr | output | 32 | Address of the missed word |
| mem_burst | output | 1 | Fetch is a four-word wrapping line burst |
| mem_burst_cap | input | 1 | Memory can serve a burst for the request being accepted |
| mem_ack | input | 1 | Memory delivers one word on `mem_rdata` |
| mem_rdata | input | 32 | Memory read data |

## Verification
A hit answers exactly one cycle after acceptance. A miss shows `mem_req` one cycle after acceptance and answers exactly one cycle after the first `mem_ack`. An idle flush drops `cpu_ready` combinationally within the same cycle. The bench drives all inputs and samples all outputs at the falling clock edge. It checks a hit or a miss-request at the first falling edge after acceptance. It checks a flush a short delay after it drives `cpu_flush`. The memory responder records the cycle number at which it raised the first acknowledge, and the bench requires `cpu_rvalid` to be first seen one cycle later. A reference model of tags and per-word valids predicts every hit, miss and burst flag. The responder adds random wait states, so the response timing is exercised beyond the minimum two-then-one cadence.

// File: rtl/dmc_pkg.sv
// Shared definitions for the direct-mapped read cache.
// Assumes nothing beyond the fill controller's two-state sequencing.
package dmc_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
// Tag and per-word valid storage for all lines.
// Applies the sub-line rule: the first word written for a fill into a line whose
// tag differs replaces the tag and leaves only that word valid. Later words just
// set their own valid bit. A flush clears all valid bits and takes priority.
module dmc_tag_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int TAG_W  = 24,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [WORDS-1:0]  rd_vld,
    input  logic              flush_clr,
    input  logic              wr_en,
    input  logic              wr_first,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [TAG_W-1:0]  wr_tag,
    output logic              vld_any
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];
    logic [WORDS-1:0] word_onehot;

    // One-hot mask of the word being written.
    assign word_onehot = {{(WORDS-1){1'b0}}, 1'b1} << wr_word;

    // Update tags and valids on reset, flush and fill writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                vld_q[i] <= '0;
            end
        end else if (flush_clr) begin
            for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
        end else if (wr_en) begin
            if (wr_first && (tag_q[wr_idx] != wr_tag)) begin
                tag_q[wr_idx] <= wr_tag;
                vld_q[wr_idx] <= word_onehot;
            end else begin
                vld_q[wr_idx] <= vld_q[wr_idx] | word_onehot;
            end
        end
    end

    // Lookup port for the line addressed by the processor.
    assign rd_tag = tag_q[rd_idx];
    assign rd_vld = vld_q[rd_idx];

    // OR-reduce all valid bits across lines (observed by the checker).
    always_comb begin
        vld_any = 1'b0;
        for (int i = 0; i < LINES; i++) vld_any = vld_any | (|vld_q[i]);
    end
endmodule

// File: rtl/dmc_data_store.sv
// Word storage, LINES x WORDS entries, with one write port and one
// combinational read port. Contents are unreset; valid bits qualify them.
module dmc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_q [LINES*WORDS];

    // Store each filled word at its line/word position.
    always_ff @(posedge clk) begin
        if (wr_en) word_q[{wr_idx, wr_word}] <= wr_data;
    end

    // Read the word the processor addresses.
    assign rd_data = word_q[{rd_idx, rd_word}];
endmodule

// File: rtl/dmc_fill_ctl.sv
// Miss and fill sequencer. Accepts requests only when idle with no flush
// outstanding. On a miss it holds the memory request until the last word
// arrives, either a single word or a wrapping four-word burst. Flushes raised
// mid-fill are held and applied in the first idle cycle.
// Assumes memory acknowledges exactly one word per mem_ack pulse.
module dmc_fill_ctl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int OFS_W  = 2,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int WADR_W = ADDR_W - OFS_W,
    localparam int TAG_W  = WADR_W - IDX_W - WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [WADR_W-1:0] req_waddr,
    input  logic              cpu_inhibit,
    input  logic              cpu_flush,
    input  logic              lookup_hit,
    input  logic              mem_ack,
    input  logic              mem_burst_cap,
    output logic              cpu_ready,
    output logic              accept,
    output logic              flush_clr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_burst,
    output logic              wr_en,
    output logic              wr_first,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WSEL_W-1:0] wr_word,
    output logic [TAG_W-1:0]  wr_tag,
    output logic              mem_ret
);
    fill_state_e       state_q;
    logic [WADR_W-1:0] waddr_q;
    logic              inh_q;
    logic              burst_q;
    logic [WSEL_W-1:0] cnt_q;
    logic              flush_pend_q;
    logic              idle;
    logic              last_word;

    // Handshake and flush decode.
    assign idle      = (state_q == FS_IDLE);
    assign cpu_ready = idle && !flush_pend_q && !cpu_flush;
    assign accept    = cpu_req && cpu_ready;
    assign flush_clr = idle && (flush_pend_q || cpu_flush);

    // Memory side and fill write decode.
    assign mem_req   = (state_q == FS_FILL);
    assign mem_addr  = {waddr_q, {OFS_W{1'b0}}};
    assign mem_burst = burst_q;
    assign wr_tag    = waddr_q[WADR_W-1 -: TAG_W];
    assign wr_idx    = waddr_q[WSEL_W +: IDX_W];
    assign wr_word   = waddr_q[WSEL_W-1:0] + cnt_q;
    assign wr_first  = (cnt_q == '0);
    assign wr_en     = mem_req && mem_ack && !inh_q;
    assign mem_ret   = mem_req && mem_ack && wr_first;
    assign last_word = !burst_q || (cnt_q == WSEL_W'(WORDS - 1));

    // Sequence fills and hold a flush raised while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= FS_IDLE;
            waddr_q      <= '0;
            inh_q        <= 1'b0;
            burst_q      <= 1'b0;
            cnt_q        <= '0;
            flush_pend_q <= 1'b0;
        end else begin
            if (idle)           flush_pend_q <= 1'b0;
            else if (cpu_flush) flush_pend_q <= 1'b1;

            case (state_q)
                FS_IDLE: begin
                    if (accept && !lookup_hit) begin
                        state_q <= FS_FILL;
                        waddr_q <= req_waddr;
                        inh_q   <= cpu_inhibit;
                        burst_q <= mem_burst_cap && !cpu_inhibit;
                        cnt_q   <= '0;
                    end
                end
                FS_FILL: begin
                    if (mem_ack) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (last_word) state_q <= FS_IDLE;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dm_read_cache.sv
// Direct-mapped read cache with per-word valid bits and optional burst fill.
// Looks up tag and valid combinationally in the request cycle and registers
// the response. Assumes word-aligned reads; address bits below the word are
// ignored.
module dm_read_cache #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    localparam int OFS_W  = $clog2(DATA_W / 8),
    localparam int IDX_W  = $clog2(LINES),
    localparam int WSEL_W = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - OFS_W - IDX_W - WSEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_inhibit,
    input  logic              cpu_flush,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_burst,
    input  logic              mem_burst_cap,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_word;
    logic [TAG_W-1:0]  line_tag;
    logic [WORDS-1:0]  line_vld;
    logic [DATA_W-1:0] hit_data;
    logic              lookup_hit;
    logic              accept;
    logic              flush_clr;
    logic              wr_en;
    logic              wr_first;
    logic [IDX_W-1:0]  wr_idx;
    logic [WSEL_W-1:0] wr_word;
    logic [TAG_W-1:0]  wr_tag;
    logic              mem_ret;
    logic              vld_any;
    logic              unused_ofs;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    // Split the request address into tag, line and word fields.
    assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx    = cpu_addr[OFS_W+WSEL_W +: IDX_W];
    assign req_word   = cpu_addr[OFS_W +: WSEL_W];
    assign unused_ofs = ^cpu_addr[OFS_W-1:0];

    // Hit when not inhibited, the tag matches and the word is valid.
    assign lookup_hit = !cpu_inhibit && line_vld[req_word] && (line_tag == req_tag);

    dmc_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_tag   (line_tag),
        .rd_vld   (line_vld),
        .flush_clr(flush_clr),
        .wr_en    (wr_en),
        .wr_first (wr_first),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word),
        .wr_tag   (wr_tag),
        .vld_any  (vld_any)
    );

    dmc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_word(wr_word),
        .wr_data(mem_rdata),
        .rd_idx (req_idx),
        .rd_word(req_word),
        .rd_data(hit_data)
    );

    dmc_fill_ctl #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS), .OFS_W(OFS_W)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .req_waddr    (cpu_addr[ADDR_W-1:OFS_W]),
        .cpu_inhibit  (cpu_inhibit),
        .cpu_flush    (cpu_flush),
        .lookup_hit   (lookup_hit),
        .mem_ack      (mem_ack),
        .mem_burst_cap(mem_burst_cap),
        .cpu_ready    (cpu_ready),
        .accept       (accept),
        .flush_clr    (flush_clr),
        .mem_req      (mem_req),
        .mem_addr     (mem_addr),
        .mem_burst    (mem_burst),
        .wr_en        (wr_en),
        .wr_first     (wr_first),
        .wr_idx       (wr_idx),
        .wr_word      (wr_word),
        .wr_tag       (wr_tag),
        .mem_ret      (mem_ret)
    );

    // Register the response from either a hit or the first fill word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= (accept && lookup_hit) || mem_ret;
            if (accept && lookup_hit) rdata_q <= hit_data;
            else if (mem_ret)         rdata_q <= mem_rdata;
        end
    end

    assign cpu_rvalid = rvalid_q;
    assign cpu_rdata  = rdata_q;
endmodule

// File: rtl/dm_read_cache_chk.sv
// Protocol checker for dm_read_cache, attached with bind. It watches the
// ports plus the flush strobe and the any-valid summary from the tag store.
module dm_read_cache_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_req,
    input logic cpu_ready,
    input logic cpu_inhibit,
    input logic cpu_flush,
    input logic cpu_rvalid,
    input logic mem_req,
    input logic mem_burst,
    input logic mem_ack,
    input logic mem_burst_cap,
    input logic flush_clr,
    input logic vld_any
);
    // R1: the cycle after reset is held, nothing is outstanding or valid.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !mem_req && !cpu_rvalid && !vld_any);

    // R4: a memory request only starts after an accepted access.
    p_miss_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(cpu_req && cpu_ready));

    // R5: a burst is only requested when memory offered it and no inhibit.
    p_burst_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req) && mem_burst) |-> $past(mem_burst_cap && !cpu_inhibit));

    // R6: a response follows either an acceptance or a memory word.
    p_rvalid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> ($past(mem_req && mem_ack) || $past(cpu_req && cpu_ready)));

    // R7: an inhibited access goes to memory as a single word.
    p_inhibit_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_inhibit) |=> (mem_req && !mem_burst));

    // R8: applying a flush empties the cache and blocks new requests.
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_clr |=> !vld_any);
    p_flush_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_clr || cpu_flush) |-> !cpu_ready);

    // R9: no acceptance while a fill is outstanding.
    p_fill_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);
endmodule

bind dm_read_cache dm_read_cache_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .cpu_ready    (cpu_ready),
    .cpu_inhibit  (cpu_inhibit),
    .cpu_flush    (cpu_flush),
    .cpu_rvalid   (cpu_rvalid),
    .mem_req      (mem_req),
    .mem_burst    (mem_burst),
    .mem_ack      (mem_ack),
    .mem_burst_cap(mem_burst_cap),
    .flush_clr    (flush_clr),
    .vld_any      (vld_any)
);

// File: tb/dm_read_cache_test.sv
// Bench for dm_read_cache: directed corner cases plus seeded random reads,
// checked against a tag/valid reference model and a computed memory image.
module dm_read_cache_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_inhibit, cpu_flush;
    logic [31:0] cpu_addr;
    logic        cpu_ready, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_burst, mem_burst_cap, mem_ack;
    logic [31:0] mem_addr, mem_rdata;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    int unsigned cyc = 0;
    int unsigned ack_cyc = 0;

    logic [23:0] m_tag [16];
    logic [3:0]  m_vld [16];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dm_read_cache uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_inhibit(cpu_inhibit), .cpu_flush(cpu_flush), .cpu_ready(cpu_ready),
        .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_burst(mem_burst), .mem_burst_cap(mem_burst_cap),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        return (w * 32'h9E37_79B1) ^ 32'h0F1E_2D3C;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_vld[i] = 4'h0;
    endtask

    // Memory responder: at least two clocks to the first word, then at least one per word.
    initial begin
        logic [31:0] ra;
        logic        rb;
        int          nw;
        int          gap;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n === 1'b1 && mem_req === 1'b1) begin
                ra = mem_addr;
                rb = mem_burst;
                nw = rb ? 4 : 1;
                for (int i = 0; i < nw; i++) begin
                    gap = (i == 0) ? 1 + int'($urandom % 2) : int'($urandom % 2);
                    repeat (gap) @(negedge clk);
                    mem_ack = 1'b1;
                    mem_rdata = memval({ra[31:4], ra[3:2] + 2'(i), 2'b00});
                    if (i == 0) ack_cyc = cyc;
                    @(negedge clk);
                    mem_ack = 1'b0;
                end
            end
        end
    end

    // One processor read, checked against the reference model.
    task automatic do_read(input logic [31:0] addr, input bit inh);
        int  idx, w, k;
        bit  exp_hit, exp_burst;
        idx = int'(addr[7:4]);
        w   = int'(addr[3:2]);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        exp_hit   = !inh && m_vld[idx][w] && (m_tag[idx] == addr[31:8]);
        exp_burst = !inh && mem_burst_cap;
        cpu_req = 1'b1; cpu_addr = addr; cpu_inhibit = inh;
        @(negedge clk);
        cpu_req = 1'b0;
        if (exp_hit) begin
            check(cpu_rvalid && !mem_req, "R2", "hit response one cycle, no memory",
                  {30'd0, cpu_rvalid, mem_req}, 32'd2);
            check(cpu_rdata == memval(addr), "R2", "hit data", cpu_rdata, memval(addr));
        end else begin
            check(!cpu_rvalid && mem_req, inh ? "R7" : "R4", "miss raises mem_req",
                  {30'd0, cpu_rvalid, mem_req}, 32'd1);
            check(mem_burst == exp_burst, exp_burst ? "R5" : "R4", "burst flag",
                  {31'd0, mem_burst}, {31'd0, exp_burst});
            check(mem_addr == {addr[31:2], 2'b00}, "R3", "memory word address",
                  mem_addr, {addr[31:2], 2'b00});
            k = 0;
            while (!cpu_rvalid && k < 60) begin @(negedge clk); k++; end
            check(cpu_rvalid && (cyc == ack_cyc + 1), "R6", "response one cycle after first ack",
                  cyc, ack_cyc + 1);
            check(cpu_rdata == memval(addr), "R6", "fill data", cpu_rdata, memval(addr));
            if (exp_burst)
                check(!cpu_ready, "R9", "ready low while burst continues",
                      {31'd0, cpu_ready}, 32'd0);
            if (!inh) begin
                if (exp_burst) begin
                    m_tag[idx] = addr[31:8];
                    m_vld[idx] = 4'hF;
                end else if (m_tag[idx] != addr[31:8]) begin
                    m_tag[idx] = addr[31:8];
                    m_vld[idx] = 4'b0001 << w;
                end else begin
                    m_vld[idx] = m_vld[idx] | (4'b0001 << w);
                end
            end
        end
        while (!cpu_ready) @(negedge clk);
    endtask

    task automatic do_flush();
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_flush = 1'b1;
        #1;
        check(!cpu_ready, "R8", "ready low in flush cycle", {31'd0, cpu_ready}, 32'd0);
        @(negedge clk);
        cpu_flush = 1'b0;
        model_clear();
    endtask

    // Watchdog.
    initial begin
        wait (cyc >= 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [31:0] a;
        logic [31:0] base;
        seed = $urandom(32'h5EED_0042);
        rst_n = 1'b0; cpu_req = 1'b0; cpu_addr = '0; cpu_inhibit = 1'b0;
        cpu_flush = 1'b0; mem_burst_cap = 1'b0;
        model_clear();
        for (int i = 0; i < 16; i++) m_tag[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cpu_ready && !cpu_rvalid && !mem_req, "R1", "idle after reset",
              {29'd0, cpu_ready, cpu_rvalid, mem_req}, 32'd4);

        // R4 and R3: single-word fills, same-tag keep, tag change invalidates.
        base = 32'h0000_1230;
        do_read(base, 1'b0);
        do_read(base, 1'b0);
        do_read(base + 32'd4, 1'b0);
        do_read(base, 1'b0);
        do_read(base + 32'd3, 1'b0);
        do_read(base + 32'd256, 1'b0);
        do_read(base, 1'b0);
        do_read(base + 32'd4, 1'b0);

        // R5: burst from word 2 wraps; every word then hits.
        mem_burst_cap = 1'b1;
        do_read(32'h0000_4568, 1'b0);
        for (int i = 0; i < 4; i++) do_read(32'h0000_4560 + 32'(i * 4), 1'b0);

        // R7: inhibit on a cached word and on an uncached one.
        do_read(32'h0000_4564, 1'b1);
        do_read(32'h0000_4564, 1'b0);
        do_read(32'h0000_9990, 1'b1);
        mem_burst_cap = 1'b0;
        do_read(32'h0000_9990, 1'b0);

        // R8: idle flush, then previously cached words miss.
        do_flush();
        do_read(32'h0000_4560, 1'b0);
        do_read(32'h0000_9990, 1'b0);

        // R8: flush raised during a burst is applied after it.
        mem_burst_cap = 1'b1;
        fork
            do_read(32'h0000_7774, 1'b0);
            begin
                wait (mem_req === 1'b1);
                @(negedge clk);
                cpu_flush = 1'b1;
                @(negedge clk);
                cpu_flush = 1'b0;
            end
        join
        model_clear();
        do_read(32'h0000_7778, 1'b0);

        // R3: sixteen lines displaced by addresses 256 bytes away.
        do_flush();
        mem_burst_cap = 1'b0;
        for (int i = 0; i < 16; i++) do_read(32'h0001_0000 + 32'(i * 16), 1'b0);
        for (int i = 0; i < 16; i++) do_read(32'h0001_0100 + 32'(i * 16), 1'b0);
        for (int i = 0; i < 16; i++) do_read(32'h0001_0000 + 32'(i * 16), 1'b0);

        // Random mix over a few tags.
        for (int n = 0; n < 400; n++) begin
            a = {22'd0, 2'($urandom % 3), 4'($urandom), 2'($urandom), 2'($urandom)};
            mem_burst_cap = 1'($urandom);
            if ($urandom % 33 == 0) do_flush();
            do_read(a, ($urandom % 10) == 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule